// File: doc/BRIEF.md
# Clear-on-read acquisition status register

This block is the 8-bit read-only status byte of a data-acquisition controller. It combines live FIFO level flags, three sticky event latches, an acquisition-running flag and a scan-status flag into one byte. It also raises an interrupt request from two of the latched events. The host reads the byte with a single-cycle read strobe. Any read clears all three event latches together. An event that arrives in the same cycle as a read is never lost.

The FIFO, the scan sequencer and the bus decoding are outside this block. The sequencer delivers arm, trigger, stop and scan strobes. The FIFO logic delivers level flags and single-cycle event pulses. A pre-trigger mode input decides whether arming alone starts the acquisition.

Top module: `acq_status_reg`

## Requirements
- R1: Bits 0, 1 and 2 of `rd_data` are the FIFO empty, almost-full and full inputs. They follow those inputs in the same cycle and are never latched.
- R2: A pulse on `ev_thresh`, `ev_eos` or `ev_lost` sets bit 3, bit 4 or bit 5 respectively, starting in the cycle after the pulse. The bit then stays at 1 until a read.
- R3: `rd_data` always shows the current register value, so a read returns the value held before the read. In the cycle after `rd_stb`, bits 3, 4 and 5 are all 0, unless R4 applies.
- R4: If an event pulse coincides with `rd_stb`, the read returns the pre-read byte, and that event's bit is 1 in the following cycle.
- R5: Bit 7 is 1 after reset. It is 0 from the cycle after `scan_start` and 1 from the cycle after `scan_done`. If both strobes arrive together, `scan_start` wins.
- R6: With `pretrig_mode` = 1, `arm_stb` sets bit 6 in the following cycle.
- R7: With `pretrig_mode` = 0, `arm_stb` only arms the block and bit 6 stays 0. A later `trig_stb` sets bit 6 in the following cycle. A `trig_stb` while not armed is ignored.
- R8: `stop_stb` clears bit 6 and the armed state in the following cycle. It overrides an arm or trigger in the same cycle.
- R9: `irq` = (bit 3 AND `irq_en_thresh`) OR (bit 4 AND `irq_en_eos`), in the same cycle. Bit 5 never drives `irq`.
- R10: While `rst_n` is low, the event bits and bit 6 are 0, bit 7 is 1, the block is disarmed and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| fifo_empty | input | 1 | FIFO empty level |
| fifo_afull | input | 1 | FIFO almost-full level |
| fifo_full | input | 1 | FIFO full level |
| ev_thresh | input | 1 | Single-cycle pulse: FIFO threshold crossed |
| ev_eos | input | 1 | Single-cycle pulse: end of scan |
| ev_lost | input | 1 | Single-cycle pulse: data lost |
| arm_stb | input | 1 | Arm command strobe |
| trig_stb | input | 1 | Trigger strobe |
| stop_stb | input | 1 | Acquisition-stop strobe |
| scan_start | input | 1 | Scan begins strobe |
| scan_done | input | 1 | Scan completed strobe |
| pretrig_mode | input | 1 | 1 = acquisition runs from arm |
| irq_en_thresh | input | 1 | Interrupt enable for the threshold event |
| irq_en_eos | input | 1 | Interrupt enable for the end-of-scan event |
| rd_stb | input | 1 | Single-cycle host read strobe |
| rd_data | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |

## Verification
Results are due at two different times. The FIFO bits and `irq` are combinational from their inputs and the latches, so they are due in the same cycle. The event, running and scan bits each pass through one register, so they are due one clock edge after their strobe.

The bench drives every strobe for exactly one cycle. It waits one rising edge, samples 1 ns later, and then clears the strobes. The read-race case is checked twice: once before the edge, for the returned byte, and once after it, for the surviving bit. Live-flag checks change an input and sample without any clock edge in between.

// File: rtl/acq_status_pkg.sv
package acq_status_pkg;
  localparam int FIFO_W  = 3;
  localparam int EVT_W   = 3;
  localparam int STAT_W  = FIFO_W + EVT_W + 2;
  localparam int EVT_THR  = 0;
  localparam int EVT_EOS  = 1;
  localparam int EVT_LOST = 2;

  // MSB first: bit 7 scan idle, bit 6 running, bits 5:3 events, bits 2:0 FIFO
  typedef struct packed {
    logic              scan_idle;
    logic              running;
    logic [EVT_W-1:0]  evt;
    logic [FIFO_W-1:0] fifo;
  } stat_t;
endpackage

// File: rtl/acq_evt_latch.sv
module acq_evt_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_pulse,
  input  logic         rd_stb,
  output logic [N-1:0] evt_q
);
  logic [N-1:0] evt_nxt;
  logic [N-1:0] evt_en;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // A new pulse wins over the clear so a coincident event survives the read
    always_comb begin
      evt_en[i]  = ev_pulse[i] | rd_stb;
      evt_nxt[i] = ev_pulse[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         evt_q[i] <= 1'b0;
      else if (evt_en[i]) evt_q[i] <= evt_nxt[i];
    end

    AST_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ev_pulse[i] |=> evt_q[i]); // R2
    AST_EVT_RACE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_pulse[i] && rd_stb) |=> evt_q[i]); // R4
    AST_EVT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !ev_pulse[i]) |=> !evt_q[i]); // R3
    AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_q[i] && !rd_stb) |=> evt_q[i]); // R2
  end
endmodule

// File: rtl/acq_run_ctrl.sv
module acq_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_stb,
  input  logic trig_stb,
  input  logic stop_stb,
  input  logic pretrig_mode,
  output logic running_q
);
  logic armed_q, armed_nxt, running_nxt, upd_en;

  always_comb begin
    armed_nxt   = armed_q;
    running_nxt = running_q;
    if (stop_stb) begin
      armed_nxt   = 1'b0;
      running_nxt = 1'b0;
    end else begin
      if (arm_stb) begin
        armed_nxt = 1'b1;
        if (pretrig_mode) running_nxt = 1'b1;
      end
      if (trig_stb && armed_q) running_nxt = 1'b1;
    end
    upd_en = stop_stb | arm_stb | trig_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      running_q <= 1'b0;
    end else if (upd_en) begin
      armed_q   <= armed_nxt;
      running_q <= running_nxt;
    end
  end

  AST_RUN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |=> (!running_q && !armed_q)); // R8
  AST_RUN_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_stb && pretrig_mode && !stop_stb) |=> running_q); // R6
  AST_RUN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running_q) |-> ($past(arm_stb && pretrig_mode) || $past(trig_stb && armed_q))); // R7
endmodule

// File: rtl/acq_scan_flag.sv
module acq_scan_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_start,
  input  logic scan_done,
  output logic scan_idle_q
);
  logic idle_nxt, idle_en;

  always_comb begin
    idle_en  = scan_start | scan_done;
    idle_nxt = !scan_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       scan_idle_q <= 1'b1;
    else if (idle_en) scan_idle_q <= idle_nxt;
  end

  AST_SCAN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |=> !scan_idle_q); // R5
  AST_SCAN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && !scan_start) |=> scan_idle_q); // R5
endmodule

// File: rtl/acq_irq_gen.sv
module acq_irq_gen
  import acq_status_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_q,
  input  logic             en_thresh,
  input  logic             en_eos,
  output logic             irq
);
  always_comb begin
    irq = (evt_q[EVT_THR] & en_thresh) | (evt_q[EVT_EOS] & en_eos);
  end

  AST_IRQ_LOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_q[EVT_THR] && !evt_q[EVT_EOS]) |-> !irq); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_thresh && !en_eos) |-> !irq); // R9
endmodule

// File: rtl/acq_status_reg.sv
module acq_status_reg
  import acq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_empty,
  input  logic              fifo_afull,
  input  logic              fifo_full,
  input  logic              ev_thresh,
  input  logic              ev_eos,
  input  logic              ev_lost,
  input  logic              arm_stb,
  input  logic              trig_stb,
  input  logic              stop_stb,
  input  logic              scan_start,
  input  logic              scan_done,
  input  logic              pretrig_mode,
  input  logic              irq_en_thresh,
  input  logic              irq_en_eos,
  input  logic              rd_stb,
  output logic [STAT_W-1:0] rd_data,
  output logic              irq
);
  logic [EVT_W-1:0] ev_pulse;
  logic [EVT_W-1:0] evt_q;
  logic             running_q;
  logic             scan_idle_q;
  stat_t            stat;

  always_comb begin
    ev_pulse           = '0;
    ev_pulse[EVT_THR]  = ev_thresh;
    ev_pulse[EVT_EOS]  = ev_eos;
    ev_pulse[EVT_LOST] = ev_lost;
  end

  acq_evt_latch #(.N(EVT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .rd_stb(rd_stb), .evt_q(evt_q)
  );

  acq_run_ctrl u_run (
    .clk(clk), .rst_n(rst_n), .arm_stb(arm_stb), .trig_stb(trig_stb),
    .stop_stb(stop_stb), .pretrig_mode(pretrig_mode), .running_q(running_q)
  );

  acq_scan_flag u_scan (
    .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .scan_done(scan_done),
    .scan_idle_q(scan_idle_q)
  );

  acq_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .evt_q(evt_q), .en_thresh(irq_en_thresh),
    .en_eos(irq_en_eos), .irq(irq)
  );

  always_comb begin
    stat.scan_idle = scan_idle_q;
    stat.running   = running_q;
    stat.evt       = evt_q;
    stat.fifo      = {fifo_full, fifo_afull, fifo_empty};
    rd_data        = stat;
  end

  AST_FIFO_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[FIFO_W-1:0] == {fifo_full, fifo_afull, fifo_empty}); // R1
  AST_RD_STABLE_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !ev_thresh && !ev_eos && !ev_lost) |=> $stable(rd_data[5:3])); // R2
endmodule

// File: tb/acq_status_reg_test.sv
`timescale 1ns/1ps
module acq_status_reg_test;
  logic clk = 1'b0;
  logic rst_n;
  logic fifo_empty, fifo_afull, fifo_full;
  logic ev_thresh, ev_eos, ev_lost;
  logic arm_stb, trig_stb, stop_stb, scan_start, scan_done;
  logic pretrig_mode, irq_en_thresh, irq_en_eos, rd_stb;
  logic [7:0] rd_data;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  acq_status_reg uut (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_afull(fifo_afull),
    .fifo_full(fifo_full), .ev_thresh(ev_thresh), .ev_eos(ev_eos), .ev_lost(ev_lost),
    .arm_stb(arm_stb), .trig_stb(trig_stb), .stop_stb(stop_stb),
    .scan_start(scan_start), .scan_done(scan_done), .pretrig_mode(pretrig_mode),
    .irq_en_thresh(irq_en_thresh), .irq_en_eos(irq_en_eos), .rd_stb(rd_stb),
    .rd_data(rd_data), .irq(irq)
  );

  // fifo {full,afull,empty}; ev {lost,eos,thr}; en {eos,thr}
  typedef struct packed {
    logic [2:0] fifo;
    logic [2:0] ev;
    logic       arm, trig, stop, sst, sdn, pre;
    logic [1:0] en;
    logic       rd;
    logic [7:0] exp_d;
    logic       exp_irq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{3'b001,3'b000,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,8'h81,1'b0}, // R1
    '{3'b000,3'b001,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,8'h88,1'b0}, // R2
    '{3'b000,3'b000,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,1'b0,8'h88,1'b1}, // R9
    '{3'b000,3'b000,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,1'b1,8'h80,1'b0}, // R3
    '{3'b010,3'b010,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,1'b0,8'h92,1'b1}, // R2 R9
    '{3'b000,3'b100,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,1'b1,8'hA0,1'b0}, // R4 R9
    '{3'b000,3'b000,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,1'b1,8'h80,1'b0}, // R3
    '{3'b100,3'b000,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,1'b0,8'h04,1'b0}, // R5
    '{3'b100,3'b000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,8'h04,1'b0}, // R7
    '{3'b100,3'b000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,8'h44,1'b0}, // R7
    '{3'b100,3'b000,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'b00,1'b0,8'hC4,1'b0}, // R5
    '{3'b100,3'b000,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,8'h84,1'b0}, // R8
    '{3'b100,3'b000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,8'h84,1'b0}, // R7
    '{3'b100,3'b000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,1'b0,8'hC4,1'b0}, // R6
    '{3'b100,3'b001,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'b01,1'b0,8'h8C,1'b1}, // R8 R9
    '{3'b100,3'b000,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b01,1'b1,8'h84,1'b0}  // R3
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clr_strobes();
    {ev_thresh, ev_eos, ev_lost, arm_stb, trig_stb, stop_stb} = '0;
    {scan_start, scan_done, rd_stb} = '0;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp_v);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    {fifo_empty, fifo_afull, fifo_full, pretrig_mode, irq_en_thresh, irq_en_eos} = '0;
    clr_strobes();
    tick(); tick();
    chk("R10 reset byte", rd_data, 8'h80);
    chk("R10 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      {fifo_full, fifo_afull, fifo_empty} = VEC[i].fifo;
      {ev_lost, ev_eos, ev_thresh}        = VEC[i].ev;
      arm_stb = VEC[i].arm; trig_stb = VEC[i].trig; stop_stb = VEC[i].stop;
      scan_start = VEC[i].sst; scan_done = VEC[i].sdn;
      pretrig_mode = VEC[i].pre;
      {irq_en_eos, irq_en_thresh} = VEC[i].en;
      rd_stb = VEC[i].rd;
      tick();
      clr_strobes();
      #0;
      chk($sformatf("R1-table row %0d byte", i), rd_data, VEC[i].exp_d);
      chk($sformatf("R9 table row %0d irq", i), {7'b0, irq}, {7'b0, VEC[i].exp_irq});
    end

    // R4: read coinciding with a new event returns the old byte and keeps the bit
    {fifo_full, fifo_afull, fifo_empty} = 3'b000;
    {irq_en_eos, irq_en_thresh} = 2'b00;
    pretrig_mode = 1'b0;
    stop_stb = 1'b1; ev_thresh = 1'b1; tick(); clr_strobes();
    rd_stb = 1'b1; ev_thresh = 1'b1; #1;
    chk("R3 R4 byte returned during read", rd_data, 8'h88);
    tick(); clr_strobes();
    chk("R4 bit survives read", rd_data, 8'h88);
    rd_stb = 1'b1; tick(); clr_strobes();
    chk("R3 cleared after plain read", rd_data, 8'h80);

    // R1: live flags change with no clock edge
    @(negedge clk);
    fifo_full = 1'b1; #0.5;
    chk("R1 full live", rd_data, 8'h84);
    fifo_full = 1'b0; fifo_empty = 1'b1; #0.5;
    chk("R1 empty live", rd_data, 8'h81);

    // R5: start and done together -> start wins
    scan_start = 1'b1; scan_done = 1'b1; tick(); clr_strobes();
    chk("R5 start wins", rd_data, 8'h01);
    scan_done = 1'b1; tick(); clr_strobes();

    // R8: stop overrides arm in pre-trigger mode
    pretrig_mode = 1'b1; arm_stb = 1'b1; stop_stb = 1'b1; tick(); clr_strobes();
    chk("R8 stop beats arm", rd_data, 8'h81);
    // R8: stop disarms, later trigger in non-pretrigger mode ignored
    pretrig_mode = 1'b0; arm_stb = 1'b1; tick(); clr_strobes();
    stop_stb = 1'b1; tick(); clr_strobes();
    trig_stb = 1'b1; tick(); clr_strobes();
    chk("R8 R7 disarmed trigger ignored", rd_data, 8'h81);

    // R9: lost event alone with both enables never interrupts
    {irq_en_eos, irq_en_thresh} = 2'b11;
    ev_lost = 1'b1; tick(); clr_strobes();
    chk("R9 lost no irq byte", rd_data, 8'hA1);
    chk("R9 lost no irq", {7'b0, irq}, 8'h00);

    // R10: asynchronous reset in mid activity
    pretrig_mode = 1'b1; arm_stb = 1'b1; ev_eos = 1'b1; scan_start = 1'b1;
    tick(); clr_strobes();
    #1 rst_n = 1'b0; #1;
    fifo_empty = 1'b0;
    #0.5;
    chk("R10 async reset byte", rd_data, 8'h80);
    chk("R10 async reset irq", {7'b0, irq}, 8'h00);
    tick(); rst_n = 1'b1; tick();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule